// File: doc/BRIEF.md
# Read-After-Read Hazard Pacer

This block sits between a host request port and a slave register bus on which some reads have side effects. Certain registers show stale contents if they are read too soon after one of those reads. The pacer maps every read address to the hazard rules it starts or is subject to. It keeps a down-counter for each rule. When a read would break a rule, the pacer holds that read until the rule's interval has run out. Writes, and reads that no live rule covers, go straight to the bus in the same cycle.

While a read is held, the `mode_dummy_i` input picks one of two behaviours. In stall mode the pacer leaves the bus idle. In filler mode it issues a harmless read of a test register in each held cycle and throws the returned data away. Each rule's interval is given in nanoseconds and converted to bus cycles from the `CYCLE_NS` parameter, rounding up. With the default 45 ns cycle, the receive FIFO rules need 3 cycles, the drop counter needs 4, and the other rules need 1. Cycles that pass during unrelated traffic or idle time count toward the wait.

Top module: `rar_pacer`

## Requirements
- R1: After reset no rule is pending: the first read of any register, including a rule target, is accepted in the cycle it is presented (`req_ready_o` high, bus access issued).
- R2: A write is passed to the bus in the cycle it is presented, with `req_ready_o` high, even while a rule is pending. A write to a rule's source register does not start that rule.
- R3: After a read of the receive data FIFO (`A_RXD`) or the receive status FIFO (`A_RXS`) is issued, a read of the receive FIFO information register (`A_RXINFO`) is held until ceil(135/CYCLE_NS) cycles have passed, which is 3 cycles by default. That read is issued in cycle t+4 at the earliest.
- R4: After a read of the transmit status FIFO (`A_TXS`), a read of the transmit FIFO information register (`A_TXINFO`) is held for ceil(135/CYCLE_NS) cycles, which is 3 cycles by default.
- R5: Two reads of the dropped-frame counter (`A_DROP`) are separated by at least ceil(180/CYCLE_NS) held cycles, which is 4 cycles by default.
- R6: While `csr_auto_i` is high, a read of the CSR command register (`A_CSRC`) is held for ceil(45/CYCLE_NS) cycles after a read of the CSR data register (`A_CSRD`), which is 1 cycle by default. While `csr_auto_i` is low, that pair is not delayed.
- R7: Two reads of the auto-negotiation expansion register (`A_ANEXP`) are separated by at least ceil(45/CYCLE_NS) held cycles, which is 1 cycle by default.
- R8: In stall mode (`mode_dummy_i`=0), a held read keeps `req_ready_o` low and `dev_valid_o` low.
- R9: In filler mode (`mode_dummy_i`=1), each held cycle drives a read of `A_TEST` on the bus (`dev_valid_o`=1, `dev_we_o`=0) with `rsp_valid_o` low. The number of filler reads equals the number of held cycles.
- R10: Reads of unrelated registers, and idle cycles, do not clear a pending rule, but they count toward its interval. If the interval has already passed, no hold and no filler is inserted.
- R11: A read pair that no rule covers (for example `A_RXD` followed by `A_TXINFO`) is not delayed.
- R12: An accepted read raises `rsp_valid_o` in the same cycle, and `rsp_rdata_o` equals `dev_rdata_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, one bus cycle per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_dummy_i | input | 1 | 1: issue filler reads while held; 0: stall |
| csr_auto_i | input | 1 | CSR auto-increment/decrement mode active |
| req_valid_i | input | 1 | Host request valid |
| req_we_i | input | 1 | Host request is a write |
| req_addr_i | input | AW | Host register address |
| req_wdata_i | input | DW | Host write data |
| req_ready_o | output | 1 | Request accepted this cycle |
| rsp_valid_o | output | 1 | Read data for the host is valid |
| rsp_rdata_o | output | DW | Read data for the host |
| dev_valid_o | output | 1 | Bus access this cycle |
| dev_we_o | output | 1 | Bus access is a write |
| dev_addr_o | output | AW | Bus address |
| dev_wdata_o | output | DW | Bus write data |
| dev_rdata_i | input | DW | Bus read data, valid in the access cycle |

## Verification
Acceptance, the bus access and the read response are all combinational from the request and the rule counters. They are due in the same cycle the request is presented. A rule counter loads on the clock edge that ends the source read. The earliest legal target read therefore lands exactly N+1 cycles after the source read. The bench drives each request at a falling edge and samples the outputs 1 ns later. It counts held cycles and filler reads one per cycle until `req_ready_o` rises, then compares the count with the interval worked out from the requirement.

// File: rtl/rar_pkg.sv
package rar_pkg;
  localparam int unsigned NUM_RULES = 6;

  typedef enum logic [2:0] {
    RL_RXD_INFO = 3'd0,
    RL_RXS_INFO = 3'd1,
    RL_TXS_INFO = 3'd2,
    RL_DROP     = 3'd3,
    RL_CSR      = 3'd4,
    RL_ANEXP    = 3'd5
  } rule_e;

  // minimum separation per rule, in ns
  function automatic int unsigned rule_ns(input int unsigned r);
    case (r)
      0, 1, 2: return 135;
      3:       return 180;
      default: return 45;
    endcase
  endfunction

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned cyc);
    return (ns + cyc - 1) / cyc;
  endfunction
endpackage

// File: rtl/rar_decode.sv
module rar_decode
  import rar_pkg::*;
#(
  parameter int unsigned    AW       = 8,
  parameter logic [AW-1:0]  A_RXD    = 8'h00,
  parameter logic [AW-1:0]  A_RXS    = 8'h10,
  parameter logic [AW-1:0]  A_TXS    = 8'h12,
  parameter logic [AW-1:0]  A_RXINFO = 8'h1f,
  parameter logic [AW-1:0]  A_TXINFO = 8'h20,
  parameter logic [AW-1:0]  A_DROP   = 8'h21,
  parameter logic [AW-1:0]  A_CSRD   = 8'h29,
  parameter logic [AW-1:0]  A_CSRC   = 8'h28,
  parameter logic [AW-1:0]  A_ANEXP  = 8'h30
) (
  input  logic [AW-1:0]        addr_i,
  output logic [NUM_RULES-1:0] src_o,
  output logic [NUM_RULES-1:0] tgt_o
);
  always_comb begin
    src_o = '0;
    tgt_o = '0;
    src_o[RL_RXD_INFO] = (addr_i == A_RXD);
    src_o[RL_RXS_INFO] = (addr_i == A_RXS);
    src_o[RL_TXS_INFO] = (addr_i == A_TXS);
    src_o[RL_DROP]     = (addr_i == A_DROP);
    src_o[RL_CSR]      = (addr_i == A_CSRD);
    src_o[RL_ANEXP]    = (addr_i == A_ANEXP);
    tgt_o[RL_RXD_INFO] = (addr_i == A_RXINFO);
    tgt_o[RL_RXS_INFO] = (addr_i == A_RXINFO);
    tgt_o[RL_TXS_INFO] = (addr_i == A_TXINFO);
    tgt_o[RL_DROP]     = (addr_i == A_DROP);
    tgt_o[RL_CSR]      = (addr_i == A_CSRC);
    tgt_o[RL_ANEXP]    = (addr_i == A_ANEXP);
  end
endmodule

// File: rtl/rar_timer.sv
module rar_timer #(
  parameter int unsigned CYCLES = 1,
  parameter int unsigned CNT_W  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  output logic busy_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (arm_i)        cnt_q <= CNT_W'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/rar_pacer.sv
module rar_pacer
  import rar_pkg::*;
#(
  parameter int unsigned    AW       = 8,
  parameter int unsigned    DW       = 32,
  parameter int unsigned    CYCLE_NS = 45,
  parameter logic [AW-1:0]  A_RXD    = 8'h00,
  parameter logic [AW-1:0]  A_RXS    = 8'h10,
  parameter logic [AW-1:0]  A_TXS    = 8'h12,
  parameter logic [AW-1:0]  A_RXINFO = 8'h1f,
  parameter logic [AW-1:0]  A_TXINFO = 8'h20,
  parameter logic [AW-1:0]  A_DROP   = 8'h21,
  parameter logic [AW-1:0]  A_CSRD   = 8'h29,
  parameter logic [AW-1:0]  A_CSRC   = 8'h28,
  parameter logic [AW-1:0]  A_ANEXP  = 8'h30,
  parameter logic [AW-1:0]  A_TEST   = 8'h19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_dummy_i,
  input  logic          csr_auto_i,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          dev_valid_o,
  output logic          dev_we_o,
  output logic [AW-1:0] dev_addr_o,
  output logic [DW-1:0] dev_wdata_o,
  input  logic [DW-1:0] dev_rdata_i
);
  localparam int unsigned MAX_CYC = ns_to_cyc(180, CYCLE_NS);
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic [NUM_RULES-1:0] src_hit, tgt_hit, busy, arm, hold_vec;
  logic blocked, issue_rd;

  rar_decode #(
    .AW(AW), .A_RXD(A_RXD), .A_RXS(A_RXS), .A_TXS(A_TXS), .A_RXINFO(A_RXINFO),
    .A_TXINFO(A_TXINFO), .A_DROP(A_DROP), .A_CSRD(A_CSRD), .A_CSRC(A_CSRC),
    .A_ANEXP(A_ANEXP)
  ) u_dec (
    .addr_i(req_addr_i),
    .src_o (src_hit),
    .tgt_o (tgt_hit)
  );

  for (genvar r = 0; r < NUM_RULES; r++) begin : g_rule
    localparam int unsigned CYC = ns_to_cyc(rule_ns(r), CYCLE_NS);
    logic en;
    // CSR rule only live in auto-step mode
    if (r == int'(RL_CSR)) begin : g_gated
      assign en = csr_auto_i;
    end else begin : g_open
      assign en = 1'b1;
    end
    assign arm[r]      = issue_rd & src_hit[r] & en;
    assign hold_vec[r] = busy[r] & tgt_hit[r] & en;

    rar_timer #(.CYCLES(CYC), .CNT_W(CNT_W)) u_tmr (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .arm_i (arm[r]),
      .busy_o(busy[r])
    );
  end

  assign blocked     = req_valid_i & ~req_we_i & (|hold_vec);
  assign issue_rd    = req_valid_i & ~req_we_i & ~blocked;
  assign req_ready_o = ~blocked;

  assign dev_valid_o = req_valid_i & (~blocked | mode_dummy_i);
  assign dev_we_o    = req_we_i;
  assign dev_addr_o  = blocked ? A_TEST : req_addr_i;
  assign dev_wdata_o = req_wdata_i;

  // filler read data is dropped: response only for accepted reads
  assign rsp_valid_o = issue_rd;
  assign rsp_rdata_o = dev_rdata_i;
endmodule

// File: rtl/rar_pacer_chk.sv
module rar_pacer_chk #(
  parameter int unsigned   AW        = 8,
  parameter logic [AW-1:0] TEST_ADDR = 8'h19,
  parameter logic [AW-1:0] DROP_ADDR = 8'h21
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mode_dummy_i,
  input logic          req_valid_i,
  input logic          req_we_i,
  input logic [AW-1:0] req_addr_i,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic          dev_valid_o,
  input logic          dev_we_o,
  input logic [AW-1:0] dev_addr_o
);
  logic held, drop_rd;
  assign held    = req_valid_i & ~req_ready_o;
  assign drop_rd = dev_valid_o & ~dev_we_o & req_ready_o & (dev_addr_o == DROP_ADDR);

  p_write_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i) |-> (req_ready_o && dev_valid_o && dev_we_o && dev_addr_o == req_addr_i));

  p_drop_gap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_rd |=> !drop_rd);

  p_stall_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && !mode_dummy_i) |-> !dev_valid_o);

  p_filler_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && mode_dummy_i) |-> (dev_valid_o && !dev_we_o && dev_addr_o == TEST_ADDR));

  p_filler_no_rsp_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held |-> !rsp_valid_o);

  p_rsp_accept_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (req_valid_i && req_ready_o && !req_we_i && dev_valid_o));
endmodule

bind rar_pacer rar_pacer_chk #(.AW(AW), .TEST_ADDR(A_TEST), .DROP_ADDR(A_DROP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_dummy_i(mode_dummy_i),
  .req_valid_i (req_valid_i),
  .req_we_i    (req_we_i),
  .req_addr_i  (req_addr_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .dev_valid_o (dev_valid_o),
  .dev_we_o    (dev_we_o),
  .dev_addr_o  (dev_addr_o)
);

// File: tb/rar_pacer_bench.sv
module rar_pacer_bench;
  localparam int unsigned CYC_NS = 45;
  localparam logic [7:0] RXD = 8'h00, RXS = 8'h10, TXS = 8'h12, RXINFO = 8'h1f,
                         TXINFO = 8'h20, DROP = 8'h21, CSRD = 8'h29, CSRC = 8'h28,
                         ANEXP = 8'h30, TEST = 8'h19, OTHER = 8'h44;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic mode_dummy_i = 1'b0, csr_auto_i = 1'b1;
  logic req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [7:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic req_ready_o, rsp_valid_o, dev_valid_o, dev_we_o;
  logic [31:0] rsp_rdata_o, dev_wdata_o, dev_rdata_i;
  logic [7:0] dev_addr_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  assign dev_rdata_i = {16'hc0de, 8'h00, dev_addr_o};

  rar_pacer #(.CYCLE_NS(CYC_NS)) u_rar_pacer (.*);

  function automatic int cyc(input int ns);
    return (ns + CYC_NS - 1) / CYC_NS;
  endfunction

  task automatic check(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // presents one request, returns held cycles and filler reads
  task automatic do_req(input logic we, input logic [7:0] a, input string rq,
                        output int waits, output int fills);
    waits = 0;
    fills = 0;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = {24'h0, a} ^ 32'h5a;
    forever begin
      #1;
      if (req_ready_o) begin
        if (we) check(rq, "write on bus", {dev_valid_o, dev_we_o, dev_addr_o}, {2'b11, a});
        else begin
          check(rq, "rsp_valid", rsp_valid_o, 1);
          check(rq, "rsp_rdata", rsp_rdata_o, {16'hc0de, 8'h00, a});
        end
        break;
      end
      if (dev_valid_o) begin
        fills++;
        if (dev_addr_o != TEST || dev_we_o || rsp_valid_o)
          check(rq, "filler access", {dev_we_o, rsp_valid_o, dev_addr_o}, {2'b00, TEST});
      end
      waits++;
      @(negedge clk_i);
    end
    @(posedge clk_i);
    #1 req_valid_i = 1'b0;
  endtask

  task automatic t_reset;
    int w, f;
    check("R1", "dev_valid idle", dev_valid_o, 0);
    check("R1", "rsp_valid idle", rsp_valid_o, 0);
    do_req(0, RXINFO, "R1", w, f);
    check("R1", "first target read held", w, 0);
  endtask

  task automatic t_rx(input logic dummy);
    int w, f;
    mode_dummy_i = dummy; idle(6);
    do_req(0, RXD, "R3", w, f);
    do_req(0, RXINFO, "R3", w, f);
    check("R3", "rxd->info held", w, cyc(135));
    if (dummy) check("R9", "filler count", f, cyc(135));
    else       check("R8", "stall no bus access", f, 0);
    idle(6);
    do_req(0, RXS, "R3", w, f);
    do_req(0, RXINFO, "R3", w, f);
    check("R3", "rxs->info held", w, cyc(135));
  endtask

  task automatic t_tx;
    int w, f;
    mode_dummy_i = 1'b1; idle(6);
    do_req(0, TXS, "R4", w, f);
    do_req(0, TXINFO, "R4", w, f);
    check("R4", "txs->info held", w, cyc(135));
    check("R9", "filler count tx", f, cyc(135));
  endtask

  task automatic t_drop;
    int w, f;
    mode_dummy_i = 1'b0; idle(6);
    do_req(0, DROP, "R5", w, f);
    do_req(0, DROP, "R5", w, f);
    check("R5", "drop->drop held", w, cyc(180));
  endtask

  task automatic t_csr;
    int w, f;
    mode_dummy_i = 1'b1; csr_auto_i = 1'b1; idle(6);
    do_req(0, CSRD, "R6", w, f);
    do_req(0, CSRC, "R6", w, f);
    check("R6", "csr auto held", w, cyc(45));
    csr_auto_i = 1'b0; idle(6);
    do_req(0, CSRD, "R6", w, f);
    do_req(0, CSRC, "R6", w, f);
    check("R6", "csr manual not held", w, 0);
    check("R6", "csr manual no filler", f, 0);
    csr_auto_i = 1'b1;
  endtask

  task automatic t_anexp;
    int w, f;
    mode_dummy_i = 1'b0; idle(6);
    do_req(0, ANEXP, "R7", w, f);
    do_req(0, ANEXP, "R7", w, f);
    check("R7", "anexp->anexp held", w, cyc(45));
  endtask

  task automatic t_elapsed;
    int w, f;
    mode_dummy_i = 1'b1; idle(6);
    do_req(0, RXD, "R10", w, f);
    do_req(0, OTHER, "R10", w, f);
    check("R10", "unrelated read held", w, 0);
    do_req(0, TXINFO, "R10", w, f);
    do_req(0, RXINFO, "R10", w, f);
    check("R10", "remaining hold", w, cyc(135) - 2);
    idle(6);
    do_req(0, DROP, "R10", w, f);
    idle(cyc(180));
    do_req(0, DROP, "R10", w, f);
    check("R10", "interval already passed", w, 0);
    check("R10", "no filler after expiry", f, 0);
  endtask

  task automatic t_nonhazard;
    int w, f;
    mode_dummy_i = 1'b0; idle(6);
    do_req(0, RXD, "R11", w, f);
    do_req(0, TXINFO, "R11", w, f);
    check("R11", "rxd->txinfo held", w, 0);
    do_req(0, RXD, "R12", w, f);
    check("R12", "plain read held", w, 0);
  endtask

  task automatic t_write;
    int w, f;
    mode_dummy_i = 1'b1; idle(6);
    do_req(0, RXD, "R2", w, f);
    do_req(1, RXINFO, "R2", w, f);
    check("R2", "write held", w, 0);
    idle(6);
    do_req(1, DROP, "R2", w, f);
    do_req(0, DROP, "R2", w, f);
    check("R2", "write armed rule", w, 0);
  endtask

  initial begin
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    t_reset();
    t_rx(1'b1);
    t_rx(1'b0);
    t_tx();
    t_drop();
    t_csr();
    t_anexp();
    t_elapsed();
    t_nonhazard();
    t_write();
    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule